// File: doc/BRIEF.md
# Stereo PWM Audio DAC Core

The core converts a stream of 16-bit PCM samples into two single-bit pulse-width-modulated outputs, one for the left channel and one for the right. After an external low-pass filter, these outputs give analogue audio. Software sets the core up through a 32-bit control register. It then pushes samples into a 16-entry transmit FIFO through a data address, and can poll a status word to see whether the FIFO has room.

Each sample goes through three steps: an optional inversion of its sign bit, a left shift of 0 to 7 places, and truncation to an 8-bit or 10-bit duty code. The resulting code is held for N whole PWM periods. The pulse can be placed at the start, at the end or in the middle of each period, and the two halves of a stereo word can be exchanged. A write can carry a stereo pair or a single mono sample. If the FIFO runs dry, the core keeps playing the last sample instead of going silent.

Top module: `pwm_audio_dac`

## Requirements
- R1: The control register sits at address 0 and bit 0 is the run enable. While the enable is clear, both outputs are low and no FIFO entry is consumed. Setting the enable loads the first sample one clock after the register write takes effect. The PWM count then starts at 0 in that same cycle and advances by one each clock.
- R2: Control bit 1 selects the resolution. When it is 0, a period is 256 clocks and the code is sample bits 15:8. When it is 1, a period is 1024 clocks and the code is sample bits 15:6. Both are taken after the inversion and the shift.
- R3: Control bits 3:2 set the pulse position within a period of P clocks with code C. Encoding 00 makes the output high for counts below C. Encoding 01 makes it high for counts of P−C and above. Encoding 10 makes it high from floor((P−C)/2) for C counts.
- R4: Control bits 16:9 hold N−1. Each sample drives the outputs for exactly N consecutive periods before the next one is taken.
- R5: When control bit 4 is set, bit 15 of each sample is inverted before conversion. When it is clear, samples are used unchanged as unsigned values.
- R6: Control bits 8:6 shift each sample left by 0 to 7 places, dropping bits above bit 15, before the resolution cut.
- R7: A stereo word written to the data address (address 1) places the left sample in bits 15:0 and the right sample in bits 31:16. When control bit 5 is set, the two halves drive the opposite outputs.
- R8: The FIFO holds 16 words. Bit 1 of the status word at address 2 reads 1 exactly when the FIFO is full. A write that arrives while the FIFO is full is discarded.
- R9: A data write with the wide flag low is a mono write. Its bits 15:0 drive both outputs.
- R10: When the FIFO is empty at a sample boundary, both outputs keep using the codes of the last sample taken.
- R11: A code of 0 keeps an output low for the whole period. The full-scale code (255 or 1023) makes the output high for all but one count of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; one PWM count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| bus_wide | input | 1 | Data writes: 1 stereo pair, 0 mono sample |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_left | output | 1 | Left channel PWM bit |
| pwm_right | output | 1 | Right channel PWM bit |

## Verification
The playback checks compare every clock of every period against an expected waveform built from the duty code and the alignment. Directed words cover codes 0, full scale and odd values in each alignment, which tells a mis-sized period or an off-by-one edge apart from a correct pulse. Stereo words with distinct halves, used with and without the swap bit and alongside mono writes, expose lane mix-ups. Sign inversion and shifts with non-zero low bits show whether the cut is taken from the right end of the word. Filling the FIFO past 16 entries and then playing out one period beyond the last word separates dropped writes, repeat-on-empty and a wrong repeat count.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;

    localparam int SMP_W   = 16;
    localparam int RES_LO  = 8;
    localparam int CODE_W  = 10;
    localparam int REP_W   = 8;
    localparam int SHIFT_W = 3;
    localparam int NCH     = 2;
    localparam int WORD_W  = NCH * SMP_W;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int EN_BIT        = 0;
    localparam int RES_BIT       = 1;
    localparam int ALIGN_LSB     = 2;
    localparam int INV_BIT       = 4;
    localparam int SWAP_BIT      = 5;
    localparam int SHIFT_LSB     = 6;
    localparam int REP_LSB       = SHIFT_LSB + SHIFT_W;
    localparam int CTRL_USED     = REP_LSB + REP_W;
    localparam int STAT_FULL_BIT = 1;

    localparam logic [31:0] CTRL_MASK = 32'((64'd1 << CTRL_USED) - 64'd1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CODE_W:0]   span_t;

    typedef enum logic [1:0] {
        ALIGN_LEFT   = 2'b00,
        ALIGN_RIGHT  = 2'b01,
        ALIGN_CENTER = 2'b10,
        ALIGN_RSVD   = 2'b11
    } align_e;

    typedef struct packed {
        logic [REP_W-1:0]   rep_m1;
        logic [SHIFT_W-1:0] shift;
        logic               swap;
        logic               invert;
        align_e             align;
        logic               res10;
        logic               enable;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.enable = w[EN_BIT];
        c.res10  = w[RES_BIT];
        c.align  = align_e'(w[ALIGN_LSB +: 2]);
        c.invert = w[INV_BIT];
        c.swap   = w[SWAP_BIT];
        c.shift  = w[SHIFT_LSB +: SHIFT_W];
        c.rep_m1 = w[REP_LSB +: REP_W];
        return c;
    endfunction

    // Period length in counts for the selected resolution.
    function automatic span_t period_len(input logic res10);
        return res10 ? span_t'(1 << CODE_W) : span_t'(1 << RES_LO);
    endfunction

    // Highest count of a period.
    function automatic code_t last_count(input logic res10);
        return res10 ? '1 : code_t'((1 << RES_LO) - 1);
    endfunction

    // Sign flip, shift, then cut to the active resolution.
    function automatic code_t sample_to_code(input logic [SMP_W-1:0]   s,
                                             input logic               inv,
                                             input logic [SHIFT_W-1:0] sh,
                                             input logic               res10);
        logic [SMP_W-1:0] t;
        t = s ^ {inv, {(SMP_W-1){1'b0}}};
        t = t << sh;
        if (res10)
            return t[SMP_W-1 -: CODE_W];
        return {{(CODE_W-RES_LO){1'b0}}, t[SMP_W-1 -: RES_LO]};
    endfunction

    // Output level of one channel at a given count.
    function automatic logic pwm_level(input align_e al,
                                       input logic   res10,
                                       input code_t  cnt,
                                       input code_t  code);
        span_t p, c, k, lead;
        p    = period_len(res10);
        c    = {1'b0, code};
        k    = {1'b0, cnt};
        lead = (p - c) >> 1;
        case (al)
            ALIGN_RIGHT:  return k >= (p - c);
            ALIGN_CENTER: return (k >= lead) && (k < lead + c);
            default:      return k < c;
        endcase
    endfunction

endpackage

// File: rtl/pwmdac_regs.sv
module pwmdac_regs
    import pwmdac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        fifo_full,
    output logic [31:0] ctrl_word,
    output ctrl_t       ctrl,
    output logic [31:0] rd_data
);

    logic [31:0] ctrl_q;
    logic [31:0] status_word;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (bus_wr && bus_addr == ADDR_CTRL)
            ctrl_q <= bus_wdata & CTRL_MASK;
    end

    always_comb begin
        status_word                = '0;
        status_word[STAT_FULL_BIT] = fifo_full;
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: rd_data = ctrl_q;
            ADDR_STAT: rd_data = status_word;
            default:   rd_data = '0;
        endcase
    end

    assign ctrl_word = ctrl_q;
    assign ctrl      = decode_ctrl(ctrl_q);

endmodule

// File: rtl/pwmdac_fifo.sv
module pwmdac_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   fill;
    logic          do_push, do_pop;

    assign full    = (fill == (AW+1)'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/pwmdac_seq.sv
module pwmdac_seq
    import pwmdac_pkg::*;
#(
    parameter int CH = NCH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ctrl_t                 ctrl,
    input  logic                  fifo_empty,
    input  logic [CH*SMP_W-1:0]   fifo_dout,
    output logic                  fifo_pop,
    output logic                  active,
    output code_t                 cnt,
    output code_t [CH-1:0]        chan_code
);

    logic [REP_W-1:0]    rep;
    logic                at_end, rep_done, load;
    logic [SMP_W-1:0]    lane [CH];
    code_t [CH-1:0]      next_code;

    assign at_end   = cnt >= last_count(ctrl.res10);
    assign rep_done = rep >= ctrl.rep_m1;
    assign load     = ctrl.enable && (!active || (at_end && rep_done));
    assign fifo_pop = load && !fifo_empty;

    // Lane selection: with swap, lane k reads word half CH-1-k.
    for (genvar k = 0; k < CH; k++) begin : g_lane
        assign lane[k] = ctrl.swap ? fifo_dout[(CH-1-k)*SMP_W +: SMP_W]
                                   : fifo_dout[k*SMP_W +: SMP_W];
        assign next_code[k] = sample_to_code(lane[k], ctrl.invert,
                                             ctrl.shift, ctrl.res10);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cnt       <= '0;
            rep       <= '0;
            chan_code <= '0;
        end else if (!ctrl.enable) begin
            active <= 1'b0;
            cnt    <= '0;
            rep    <= '0;
        end else begin
            active <= 1'b1;
            if (!active) begin
                cnt <= '0;
                rep <= '0;
            end else if (at_end) begin
                cnt <= '0;
                rep <= rep_done ? '0 : rep + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (fifo_pop)
                chan_code <= next_code;
        end
    end

endmodule

// File: rtl/pwmdac_chan.sv
module pwmdac_chan
    import pwmdac_pkg::*;
(
    input  align_e align,
    input  logic   res10,
    input  logic   active,
    input  code_t  cnt,
    input  code_t  code,
    output logic   pwm
);

    assign pwm = active && pwm_level(align, res10, cnt, code);

endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
    import pwmdac_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wide,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_left,
    output logic        pwm_right
);

    ctrl_t               ctrl;
    logic [31:0]         ctrl_word;
    logic                fifo_full, fifo_empty, fifo_pop, fifo_push;
    logic [WORD_W-1:0]   fifo_din, fifo_dout;
    logic                active;
    code_t               cnt;
    code_t [NCH-1:0]     chan_code;
    logic [NCH-1:0]      pwm_bits;

    pwmdac_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .fifo_full (fifo_full),
        .ctrl_word (ctrl_word),
        .ctrl      (ctrl),
        .rd_data   (bus_rdata)
    );

    assign fifo_push = bus_wr && (bus_addr == ADDR_DATA);
    assign fifo_din  = bus_wide ? bus_wdata[WORD_W-1:0]
                                : {NCH{bus_wdata[SMP_W-1:0]}};

    pwmdac_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pwmdac_seq #(.CH(NCH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .fifo_pop   (fifo_pop),
        .active     (active),
        .cnt        (cnt),
        .chan_code  (chan_code)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pwmdac_chan u_chan (
            .align  (ctrl.align),
            .res10  (ctrl.res10),
            .active (active),
            .cnt    (cnt),
            .code   (chan_code[ch]),
            .pwm    (pwm_bits[ch])
        );
    end

    assign pwm_left  = pwm_bits[0];
    assign pwm_right = pwm_bits[NCH-1];

endmodule

// File: rtl/pwmdac_audio_chk.sv
module pwmdac_audio_chk
    import pwmdac_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  enable,
    input logic  fifo_full,
    input logic  fifo_empty,
    input logic  fifo_pop,
    input logic  active,
    input code_t cnt,
    input code_t code_l,
    input code_t code_r,
    input logic  pwm_l,
    input logic  pwm_r
);

    // R1: a cleared enable silences both outputs from the next cycle.
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!pwm_l && !pwm_r));

    // R1: playback starts at count zero.
    p_start_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (cnt == '0));

    // R4: a new sample is only taken at a period start.
    p_pop_restart_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> (cnt == '0));

    // R11: a zero code keeps the output low.
    p_zero_low_l_r11: assert property (@(posedge clk) disable iff (rst)
        (code_l == '0) |-> !pwm_l);
    p_zero_low_r_r11: assert property (@(posedge clk) disable iff (rst)
        (code_r == '0) |-> !pwm_r);

    // R8: a full FIFO stays full until an entry leaves.
    p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !fifo_pop) |=> fifo_full);

    // R10: with nothing queued, the playing codes do not change.
    p_empty_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (active && fifo_empty) |=> ($stable(code_l) && $stable(code_r)));

endmodule

bind pwm_audio_dac pwmdac_audio_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (ctrl_word[0]),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .active     (active),
    .cnt        (cnt),
    .code_l     (chan_code[0]),
    .code_r     (chan_code[1]),
    .pwm_l      (pwm_left),
    .pwm_r      (pwm_right)
);

// File: tb/pwm_audio_dac_bench.sv
module pwm_audio_dac_bench;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_wide;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        pwm_left, pwm_right;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] wq [0:31];
    bit          wm [0:31];
    int          nwq;

    always #5 clk = ~clk;

    pwm_audio_dac u_pwm_audio_dac (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wide  (bus_wide),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_left  (pwm_left),
        .pwm_right (pwm_right)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d, input bit wide);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wide  = wide;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(bit en, bit r10, int al, bit inv,
                                            bit sw, int sh, int n);
        return 32'(en) | (32'(r10) << 1) | (32'(al) << 2) | (32'(inv) << 4)
             | (32'(sw) << 5) | (32'(sh) << 6) | (32'(n - 1) << 9);
    endfunction

    // Expected duty code from R2, R5, R6.
    function automatic int exp_code(logic [15:0] s, bit inv, int sh, bit r10);
        int v;
        v = int'(s);
        if (inv) v = v ^ 32'h8000;
        v = (v << sh) & 32'hFFFF;
        return r10 ? (v >> 6) : (v >> 8);
    endfunction

    // Expected level from R3: a run of 'code' high counts from a start point.
    function automatic bit exp_bit(int al, bit r10, int code, int c);
        int per, start;
        per = r10 ? 1024 : 256;
        case (al)
            1:       start = per - code;
            2:       start = (per - code) / 2;
            default: start = 0;
        endcase
        return (c >= start) && (c < start + code);
    endfunction

    task automatic push(input logic [31:0] w, input bit mono, input bit keep);
        bus_write(A_DATA, w, !mono);
        if (keep) begin
            wq[nwq] = w;
            wm[nwq] = mono;
            nwq++;
        end
    endtask

    // Plays all queued words plus one slot beyond (repeat of the last, R10).
    task automatic play(input string tag, input bit r10, input int al, input bit inv,
                        input bit sw, input int sh, input int n);
        int per;
        per = r10 ? 1024 : 256;
        bus_write(A_CTRL, mk_ctrl(1, r10, al, inv, sw, sh, n), 1'b1);
        @(negedge clk);
        for (int j = 0; j <= nwq; j++) begin
            int idx, cl, cr;
            logic [15:0] sl, sr, tmp;
            idx = (j < nwq) ? j : nwq - 1;
            sl  = wq[idx][15:0];
            sr  = wm[idx] ? wq[idx][15:0] : wq[idx][31:16];
            if (sw) begin
                tmp = sl; sl = sr; sr = tmp;
            end
            cl = exp_code(sl, inv, sh, r10);
            cr = exp_code(sr, inv, sh, r10);
            for (int p = 0; p < n; p++) begin
                int bad;
                bad = 0;
                for (int c = 0; c < per; c++) begin
                    if (pwm_left !== exp_bit(al, r10, cl, c)) bad++;
                    if (pwm_right !== exp_bit(al, r10, cr, c)) bad++;
                    @(negedge clk);
                end
                check(tag, 32'(bad), 32'd0,
                      $sformatf("slot %0d period %0d wrong cycles", j, p));
            end
        end
        bus_write(A_CTRL, mk_ctrl(0, r10, al, inv, sw, sh, n), 1'b1);
        @(negedge clk);
        check("R1", {30'd0, pwm_left, pwm_right}, 32'd0, "outputs after disable");
        repeat (5) @(negedge clk);
        check("R1", {30'd0, pwm_left, pwm_right}, 32'd0, "outputs stay low while off");
        nwq = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd2024));
        nwq       = 0;
        rst       = 1'b1;
        bus_wr    = 1'b0;
        bus_wide  = 1'b1;
        bus_addr  = A_CTRL;
        bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // Reset state (R1, R8)
        check("R1", {30'd0, pwm_left, pwm_right}, 32'd0, "outputs after reset");
        bus_read(A_CTRL, rd);
        check("R1", rd, 32'd0, "control after reset");
        bus_read(A_STAT, rd);
        check("R8", rd, 32'd0, "status after reset");

        // Left aligned, 8-bit, N=1, distinct halves (R2 R3 R7 R10)
        push(32'h40C0_1234, 0, 1);
        push(32'hFF00_0080, 0, 1);
        push(32'h0300_7F00, 0, 1);
        play("R3", 0, 0, 0, 0, 0, 1);

        // Right aligned with sign flip and N=2 (R4 R5)
        push(32'h8000_0000, 0, 1);
        push(32'h7FFF_C000, 0, 1);
        play("R4", 0, 1, 1, 0, 0, 2);

        // Center, swap, shift 3, zero and full-scale codes (R6 R7 R11)
        push(32'h0000_FFFF, 0, 1);
        push(32'h0A31_1FFF, 0, 1);
        play("R11", 0, 2, 0, 1, 3, 1);

        // Full scale and zero without shift, center 8-bit (R11)
        push(32'hFFFF_0000, 0, 1);
        play("R11", 0, 2, 0, 0, 0, 1);

        // 10-bit center with odd codes (R2 R3)
        push(32'h0140_0FC0, 0, 1);
        push(32'hFFC0_0040, 0, 1);
        play("R2", 1, 2, 0, 0, 0, 1);

        // Mono writes drive both outputs (R9)
        push(32'hDEAD_3A40, 1, 1);
        push(32'h0000_9C00, 1, 1);
        play("R9", 1, 0, 0, 0, 0, 1);

        // FIFO fill: 16 kept, 17th dropped (R8)
        for (int i = 0; i < 15; i++)
            push({8'(i * 16 + 3), 8'h00, 8'(255 - i * 9), 8'h00}, 0, 1);
        bus_read(A_STAT, rd);
        check("R8", {31'd0, rd[1]}, 32'd0, "full flag at 15 entries");
        push(32'h5500_AA00, 0, 1);
        bus_read(A_STAT, rd);
        check("R8", {31'd0, rd[1]}, 32'd1, "full flag at 16 entries");
        push(32'h0100_0100, 0, 0);
        bus_read(A_STAT, rd);
        check("R8", {31'd0, rd[1]}, 32'd1, "full flag after dropped write");
        play("R8", 0, 0, 0, 0, 0, 1);
        bus_read(A_STAT, rd);
        check("R8", {31'd0, rd[1]}, 32'd0, "full flag after drain");

        // Constrained random settings and samples (R2 R3 R4 R5 R6 R7)
        for (int t = 0; t < 6; t++) begin
            bit r10, inv, sw;
            int al, sh, n;
            r10 = 1'($urandom % 2);
            inv = 1'($urandom % 2);
            sw  = 1'($urandom % 2);
            al  = int'($urandom % 3);
            sh  = int'($urandom % 8);
            n   = 1 + int'($urandom % 2);
            push($urandom, 0, 1);
            push($urandom, 1'($urandom % 2), 1);
            play("R6", r10, al, inv, sw, sh, n);
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule